// File: doc/BRIEF.md
# Sliding-Window Pairwise Difference Engine

This block takes a stream of signed 32-bit fixed-point error samples, one for each cycle in which the input valid is high. With every error it also takes a paired filter-input sample. It keeps the last N-1 accepted samples of each stream in a shift register. When a new sample arrives, a bank of parallel saturating subtractors forms the new value minus every stored value in that same cycle. Each new sample therefore yields all of its pairwise differences at once. A full window of N samples produces all N(N-1)/2 differences in N accepted cycles, where a sequential approach would take on the order of N² steps.

The results are registered and appear one cycle after the sample is accepted. Each lane carries its own valid flag. A one-cycle strobe marks the sample that first fills the window. A sticky flag records any saturation. A synchronous clear empties both windows so that a new set of differences can start. Kernel evaluation, weight update and filtering are done elsewhere and consume these outputs.

Top module: `pde_top`

## Requirements
- R1: After reset, out_valid, lane_valid, win_done and ovf are all 0.
- R2: When in_valid is high and clr is low at a rising edge, out_valid is 1 after that edge. For every valid lane i, diff_e bits [i*32 +: 32] then equal the new error minus the error accepted i+1 samples earlier.
- R3: On the same lanes and in the same cycle, diff_x bits [i*32 +: 32] equal the new x sample minus the x sample accepted i+1 samples earlier.
- R4: Lane i of lane_valid (i = 0..N-2) is 1 only when at least i+2 samples, counting the current one, have been accepted since the last clear or reset. lane_valid is 0 whenever out_valid is 0.
- R5: A difference outside the signed 32-bit range is clamped to 0x7FFFFFFF if positive or 0x80000000 if negative. It never wraps.
- R6: ovf becomes 1 together with the outputs of any sample whose valid lanes saturate in either stream. It then stays 1 until clr or reset.
- R7: A high clr at an edge empties both windows and clears ovf. Any sample offered in the same cycle is dropped. After that edge out_valid is 0, and the next accepted sample has no valid lanes.
- R8: win_done is 1, with out_valid, for exactly the outputs of the Nth sample accepted since the last clear. It is 0 for every other sample.
- R9: A cycle with in_valid low shifts neither window and gives out_valid 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous window clear, takes priority over in_valid |
| in_valid | input | 1 | A sample pair is present this cycle |
| e_in | input | 32 | Signed error sample |
| x_in | input | 32 | Signed filter-input sample |
| out_valid | output | 1 | Registered results for an accepted sample |
| lane_valid | output | N-1 | Per-lane valid; lane i holds distance i+1 |
| diff_e | output | (N-1)*32 | Error differences, lane i at bits [i*32 +: 32] |
| diff_x | output | (N-1)*32 | Input differences, same lane layout |
| win_done | output | 1 | Outputs belong to the Nth sample since clear |
| ovf | output | 1 | Sticky saturation flag |

## Verification
The assertions assume that clr and in_valid are known 0 or 1 at every edge after reset. They also assume that one sample pair is offered for each valid cycle and that nothing upstream holds it back. The thermometer and fill properties depend on the accept count never being reset except by clr or rst_n. The stimulus drives its inputs only on falling edges and keeps every control input at a defined level. It mixes back-to-back samples, idle gaps, a clear alone, a clear offered together with a sample, and value pairs chosen to saturate both streams. The expected results come from a history model kept in the bench.

// File: rtl/pde_pkg.sv
package pde_pkg;
  localparam int unsigned SAMPLE_W = 32;
  localparam int unsigned WINDOW_N = 8;

  function automatic int unsigned lane_count(input int unsigned n);
    return n - 1;
  endfunction
endpackage

// File: rtl/pde_window.sv
module pde_window #(
  parameter int unsigned DW    = pde_pkg::SAMPLE_W,
  parameter int unsigned DEPTH = pde_pkg::WINDOW_N - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  shift,
  input  logic [DW-1:0]         din,
  output logic [DEPTH*DW-1:0]   taps
);
  logic [DW-1:0] st_q [DEPTH];
  logic [DW-1:0] st_d [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    logic [DW-1:0] src;
    if (i == 0) begin : g_head
      assign src = din;
    end else begin : g_body
      assign src = st_q[i-1];
    end

    always_comb begin
      st_d[i] = st_q[i];
      if (clr) begin
        st_d[i] = '0;
      end else if (shift) begin
        st_d[i] = src;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[i] <= '0;
      end else begin
        st_q[i] <= st_d[i];
      end
    end

    assign taps[i*DW +: DW] = st_q[i];
  end

  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !shift) |=> $stable(taps)); // R9
endmodule

// File: rtl/pde_fill.sv
module pde_fill #(
  parameter int unsigned N = pde_pkg::WINDOW_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         accept,
  output logic [N-2:0] lane_ok,
  output logic         fill_last
);
  localparam int unsigned CW = $clog2(N + 1);
  localparam logic [CW-1:0] FULL = CW'(N);

  logic [CW-1:0] fill_q;
  logic [CW-1:0] fill_d;

  always_comb begin
    fill_d = fill_q;
    if (clr) begin
      fill_d = '0;
    end else if (accept && (fill_q != FULL)) begin
      fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else begin
      fill_q <= fill_d;
    end
  end

  for (genvar i = 0; i < N - 1; i++) begin : g_ok
    assign lane_ok[i] = (fill_q >= CW'(i + 1));
  end

  assign fill_last = (fill_q == CW'(N - 1));

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FULL); // R4
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !clr && fill_q < FULL) |=> fill_q == $past(fill_q) + 1'b1); // R4
endmodule

// File: rtl/pde_lane_sub.sv
module pde_lane_sub #(
  parameter int unsigned DW = pde_pkg::SAMPLE_W
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] d,
  output logic          sat
);
  logic [DW:0] wide;

  always_comb begin
    wide = {a[DW-1], a} - {b[DW-1], b};
    sat  = wide[DW] ^ wide[DW-1];
    if (!sat) begin
      d = wide[DW-1:0];
    end else if (wide[DW]) begin
      d = {1'b1, {(DW-1){1'b0}}};
    end else begin
      d = {1'b0, {(DW-1){1'b1}}};
    end
  end
endmodule

// File: rtl/pde_top.sv
module pde_top #(
  parameter int unsigned DW = pde_pkg::SAMPLE_W,
  parameter int unsigned N  = pde_pkg::WINDOW_N
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 in_valid,
  input  logic [DW-1:0]        e_in,
  input  logic [DW-1:0]        x_in,
  output logic                 out_valid,
  output logic [N-2:0]         lane_valid,
  output logic [(N-1)*DW-1:0]  diff_e,
  output logic [(N-1)*DW-1:0]  diff_x,
  output logic                 win_done,
  output logic                 ovf
);
  localparam int unsigned LANES = pde_pkg::lane_count(N);
  localparam logic [DW-1:0] POS_RAIL = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_RAIL = {1'b1, {(DW-1){1'b0}}};

  logic                  accept;
  logic [LANES*DW-1:0]   taps_e, taps_x;
  logic [LANES*DW-1:0]   sub_e, sub_x;
  logic [LANES-1:0]      sat_e, sat_x;
  logic [LANES-1:0]      lane_ok;
  logic                  fill_last;

  assign accept = in_valid & ~clr;

  pde_window #(.DW(DW), .DEPTH(LANES)) u_win_e (
    .clk(clk), .rst_n(rst_n), .clr(clr), .shift(accept), .din(e_in), .taps(taps_e)
  );
  pde_window #(.DW(DW), .DEPTH(LANES)) u_win_x (
    .clk(clk), .rst_n(rst_n), .clr(clr), .shift(accept), .din(x_in), .taps(taps_x)
  );

  pde_fill #(.N(N)) u_fill (
    .clk(clk), .rst_n(rst_n), .clr(clr), .accept(accept),
    .lane_ok(lane_ok), .fill_last(fill_last)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pde_lane_sub #(.DW(DW)) u_sub_e (
      .a(e_in), .b(taps_e[i*DW +: DW]), .d(sub_e[i*DW +: DW]), .sat(sat_e[i])
    );
    pde_lane_sub #(.DW(DW)) u_sub_x (
      .a(x_in), .b(taps_x[i*DW +: DW]), .d(sub_x[i*DW +: DW]), .sat(sat_x[i])
    );

    AST_SAT_RAIL_E: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && sat_e[i]) |=> (diff_e[i*DW +: DW] == POS_RAIL ||
                                diff_e[i*DW +: DW] == NEG_RAIL)); // R5
    AST_SAT_RAIL_X: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && sat_x[i]) |=> (diff_x[i*DW +: DW] == POS_RAIL ||
                                diff_x[i*DW +: DW] == NEG_RAIL)); // R5
  end

  // output stage: next-state
  logic                 ov_d, ov_q;
  logic [LANES-1:0]     lv_d, lv_q;
  logic [LANES*DW-1:0]  de_d, de_q, dx_d, dx_q;
  logic                 dn_d, dn_q;
  logic                 of_d, of_q;
  logic                 hit_sat;

  assign hit_sat = |((sat_e | sat_x) & lane_ok);

  always_comb begin
    ov_d = accept;
    lv_d = accept ? lane_ok : '0;
    dn_d = accept & fill_last;
    de_d = de_q;
    dx_d = dx_q;
    if (accept) begin
      de_d = sub_e;
      dx_d = sub_x;
    end
    if (clr) begin
      of_d = 1'b0;
    end else begin
      of_d = of_q | (accept & hit_sat);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      lv_q <= '0;
      dn_q <= 1'b0;
      of_q <= 1'b0;
      de_q <= '0;
      dx_q <= '0;
    end else begin
      ov_q <= ov_d;
      lv_q <= lv_d;
      dn_q <= dn_d;
      of_q <= of_d;
      de_q <= de_d;
      dx_q <= dx_d;
    end
  end

  assign out_valid  = ov_q;
  assign lane_valid = lv_q;
  assign diff_e     = de_q;
  assign diff_x     = dx_q;
  assign win_done   = dn_q;
  assign ovf        = of_q;

  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clr) |=> out_valid); // R2
  AST_LANE_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_valid + 1'b1) & lane_valid) == '0); // R4
  AST_LANE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> lane_valid == '0); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf); // R6
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!out_valid && !ovf && !win_done)); // R7
  AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |-> (out_valid && (&lane_valid))); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R9
endmodule

// File: tb/pde_top_tb.sv
module pde_top_tb;
  localparam int DW = 32;
  localparam int N  = 8;
  localparam int L  = N - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] e_in = '0;
  logic [DW-1:0] x_in = '0;
  logic out_valid, win_done, ovf;
  logic [L-1:0] lane_valid;
  logic [L*DW-1:0] diff_e, diff_x;

  always #2 clk = ~clk;

  pde_top #(.DW(DW), .N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .e_in(e_in), .x_in(x_in), .out_valid(out_valid), .lane_valid(lane_valid),
    .diff_e(diff_e), .diff_x(diff_x), .win_done(win_done), .ovf(ovf)
  );

  typedef struct {
    logic [L-1:0]    lv;
    logic [L*DW-1:0] de;
    logic [L*DW-1:0] dx;
    logic            dn;
    logic            of;
  } exp_t;

  exp_t exp_q[$];
  logic [DW-1:0] hist_e[$];
  logic [DW-1:0] hist_x[$];
  int  fill_m = 0;
  logic ovf_m = 1'b0;
  int  checks = 0;
  int  errors = 0;
  bit  done_run = 1'b0;

  function automatic logic [DW-1:0] sat_diff(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                             output bit s);
    longint v;
    v = longint'($signed(a)) - longint'($signed(b));
    s = 1'b0;
    if (v > 64'sd2147483647) begin s = 1'b1; return 32'h7FFF_FFFF; end
    if (v < -64'sd2147483648) begin s = 1'b1; return 32'h8000_0000; end
    return v[DW-1:0];
  endfunction

  // driver: leaves caller on a falling edge
  task automatic send(input logic [DW-1:0] e, input logic [DW-1:0] x);
    exp_t it;
    bit s;
    it.lv = '0; it.de = '0; it.dx = '0;
    for (int i = 0; i < L; i++) begin
      if (fill_m + 1 >= i + 2) begin
        it.lv[i] = 1'b1;
        it.de[i*DW +: DW] = sat_diff(e, hist_e[i], s);
        if (s) ovf_m = 1'b1;
        it.dx[i*DW +: DW] = sat_diff(x, hist_x[i], s);
        if (s) ovf_m = 1'b1;
      end
    end
    it.dn = (fill_m == N - 1);
    it.of = ovf_m;
    if (fill_m < N) fill_m++;
    hist_e.push_front(e);
    hist_x.push_front(x);
    exp_q.push_back(it);
    e_in = e; x_in = x; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_clear(input bit with_sample);
    clr = 1'b1;
    if (with_sample) begin e_in = 32'h1234; x_in = 32'h5678; in_valid = 1'b1; end
    @(negedge clk);
    clr = 1'b0; in_valid = 1'b0;
    hist_e.delete(); hist_x.delete();
    for (int i = 0; i < L; i++) begin hist_e.push_back('0); hist_x.push_back('0); end
    fill_m = 0; ovf_m = 1'b0;
    check(out_valid == 1'b0, "R7 out_valid after clr", out_valid, 0);
    check(ovf == 1'b0, "R7 ovf after clr", ovf, 0);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected out_valid", 1, 0);
      end else begin
        exp_t it;
        bit ok;
        it = exp_q.pop_front();
        ok = 1'b1;
        if (lane_valid !== it.lv) begin ok = 1'b0; $display("FAIL R4 lane_valid actual=%0h expected=%0h", lane_valid, it.lv); end
        if (win_done !== it.dn) begin ok = 1'b0; $display("FAIL R8 win_done actual=%0b expected=%0b", win_done, it.dn); end
        if (ovf !== it.of) begin ok = 1'b0; $display("FAIL R6 ovf actual=%0b expected=%0b", ovf, it.of); end
        for (int i = 0; i < L; i++) begin
          if (it.lv[i]) begin
            if (diff_e[i*DW +: DW] !== it.de[i*DW +: DW]) begin
              ok = 1'b0;
              $display("FAIL R2/R5 diff_e lane %0d actual=%0h expected=%0h", i, diff_e[i*DW +: DW], it.de[i*DW +: DW]);
            end
            if (diff_x[i*DW +: DW] !== it.dx[i*DW +: DW]) begin
              ok = 1'b0;
              $display("FAIL R3/R5 diff_x lane %0d actual=%0h expected=%0h", i, diff_x[i*DW +: DW], it.dx[i*DW +: DW]);
            end
          end
        end
        checks++;
        if (!ok) errors++;
      end
    end
  end

  initial begin
    for (int i = 0; i < L; i++) begin hist_e.push_back('0); hist_x.push_back('0); end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(lane_valid == '0, "R1 lane_valid", lane_valid, 0);
    check(win_done == 1'b0, "R1 win_done", win_done, 0);
    check(ovf == 1'b0, "R1 ovf", ovf, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 R3 R4 R8: fill past a full window, back to back
    for (int k = 0; k < 10; k++) send(DW'(k * 37 - 100), DW'(1000 - k * k * 11));
    // R9: idle gap keeps window, out_valid low
    idle(1);
    check(out_valid == 1'b0, "R9 idle out_valid", out_valid, 0);
    idle(3);
    send(32'hFFFF_FF00, 32'h0000_0042);
    idle(2);
    send(32'h0001_0000, 32'hFFFE_0000);
    idle(2);
    // R7: plain clear, then refill with gaps
    do_clear(1'b0);
    for (int k = 0; k < 5; k++) begin send(DW'(k * 1000 + 7), DW'(-k * 3)); idle(k % 2); end
    // R7: clear wins over a sample offered in the same cycle
    do_clear(1'b1);
    send(32'h0000_0010, 32'h0000_0020);
    // R5 R6: saturation in both directions, then sticky
    send(32'h7FFF_0000, 32'h8000_1000);
    send(32'h8001_0000, 32'h7FFF_F000);
    send(32'h0000_0001, 32'h0000_0001);
    idle(2);
    check(ovf == 1'b1, "R6 ovf sticky while idle", ovf, 1);
    for (int k = 0; k < 6; k++) send(DW'(k), DW'(k + 1));
    idle(2);
    do_clear(1'b0);
    for (int k = 0; k < 9; k++) send(DW'(-k * 5), DW'(k * 9));
    idle(3);
    check(exp_q.size() == 0, "R2 all outputs seen", exp_q.size(), 0);
    done_run = 1'b1;
  end

  initial begin
    fork
      wait (done_run);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule